// File: doc/BRIEF.md
# Asymmetric Decode Slot Steering

This block takes the oldest entries of an instruction queue and shares them out over a set of decode slots each cycle. Every queue entry carries an instruction word and the number of micro-operations it expands to. The slots are not equal. The first slot can take an instruction that expands to several micro-operations, up to a parameterised limit. Every later slot takes only instructions that expand to exactly one micro-operation. Steering follows program order. Once the next instruction does not fit the slot it would land in, the group for that cycle ends, and that instruction waits until it is at the head and can use the first slot.

An instruction whose expansion is longer than the first slot's limit is given to a microcode sequencer instead of a slot. It always leaves alone: that cycle fills no slot. While the sequencer reports that it is busy, nothing is steered. The number of entries consumed is given combinationally in the same cycle, so the queue can move its head pointer on that clock edge. The slot and sequencer outputs are registered and appear one cycle later.

Top module: `decode_steer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `slot_vld` is all zeros and `ucode_vld` is low.
- R2: If the head entry is valid and has a micro-op count from 1 to 4, it goes to slot 0. In the next cycle, `slot_vld[0]` is 1, the word is in slot 0 and its count is in `slot0_uops`.
- R3: Window entries 1..3 go to slots 1..3 in order, each only if every earlier entry was steered, the entry is valid and its count is exactly 1. The first entry that fails these tests ends the group, and entries after it are not taken even if they would fit.
- R4: If the head entry is valid and has a count above 4, it goes to the sequencer. In the next cycle `ucode_vld` is 1 with that word and count, and no slot is valid.
- R5: `take_cnt` gives, combinationally in the same cycle, the number of window entries steered to slots or to the sequencer. The number of valid outputs in the next cycle equals that value.
- R6: While `ucode_busy` is high, `take_cnt` is 0, and in the next cycle no slot and no sequencer output is valid.
- R7: If the head entry is invalid or has a count of 0, nothing is taken and nothing is valid in the next cycle.
- R8: A sequencer handoff and a slot assignment never happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ucode_busy | input | 1 | Sequencer is busy, so steer nothing |
| win_vld | input | SLOTS | Valid flag of each window entry; bit 0 is the queue head |
| win_uops | input | SLOTS*UOP_W | Micro-op count of each entry; entry k is in bits k*UOP_W upward |
| win_insn | input | SLOTS*INSN_W | Instruction word of each entry; entry k is in bits k*INSN_W upward |
| take_cnt | output | CNT_W | Number of entries consumed this cycle (combinational) |
| slot_vld | output | SLOTS | Registered valid flag of each decode slot |
| slot_insn | output | SLOTS*INSN_W | Registered instruction word of each slot |
| slot0_uops | output | UOP_W | Registered micro-op count of slot 0 |
| ucode_vld | output | 1 | Registered sequencer handoff valid |
| ucode_insn | output | INSN_W | Registered instruction word handed to the sequencer |
| ucode_uops | output | UOP_W | Registered micro-op count handed to the sequencer |

## Verification
Some properties are checked by assertions on every cycle: the valid slots form a contiguous run starting at slot 0, a sequencer handoff never appears together with a slot, slot 0 holds a count within its limit while the sequencer gets only longer counts, the number of valid outputs equals the previous cycle's take count, and a busy cycle is followed by idle outputs. Other behaviour can only be shown by the bench's scenarios: that the correct words reach the correct slots in program order, that a group stops at a multi-micro-op entry that is not at the head and resumes with it at the head, and that invalid or zero-count heads stall the queue.

// File: rtl/decode_steer_pkg.sv
package decode_steer_pkg;
  // Per-entry fitness flags produced by the classifier
  typedef struct packed {
    logic single; // exactly one micro-op: fits any slot
    logic fits0;  // 1..SLOT0_MAX micro-ops: fits slot 0
    logic long_x; // above SLOT0_MAX: sequencer path
  } ent_class_t;
endpackage

// File: rtl/decode_steer_classify.sv
module decode_steer_classify
  import decode_steer_pkg::*;
#(
  parameter int UOP_W     = 4,
  parameter int SLOT0_MAX = 4
) (
  input  logic [UOP_W-1:0] uops,
  output ent_class_t       cls
);
  localparam logic [UOP_W-1:0] LIMIT = UOP_W'(SLOT0_MAX);
  localparam logic [UOP_W-1:0] ONE   = UOP_W'(1);

  always_comb begin
    cls.single = (uops == ONE);
    cls.fits0  = (uops != '0) && (uops <= LIMIT);
    cls.long_x = (uops > LIMIT);
  end
endmodule

// File: rtl/decode_steer_select.sv
module decode_steer_select
  import decode_steer_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic                   busy,
  input  logic       [SLOTS-1:0] vld,
  input  ent_class_t [SLOTS-1:0] cls,
  output logic       [SLOTS-1:0] run,
  output logic                   ucode_go,
  output logic       [CNT_W-1:0] take
);
  // Slot 0 admits multi-op entries; the chain continues only on single-op entries
  assign run[0]   = !busy && vld[0] && cls[0].fits0;
  assign ucode_go = !busy && vld[0] && cls[0].long_x;

  genvar k;
  generate
    for (k = 1; k < SLOTS; k++) begin : g_chain
      assign run[k] = run[k-1] && vld[k] && cls[k].single;
    end
  endgenerate

  always_comb begin
    take = CNT_W'(ucode_go);
    for (int i = 0; i < SLOTS; i++) begin
      take = take + CNT_W'(run[i]);
    end
  end
endmodule

// File: rtl/decode_steer.sv
module decode_steer
  import decode_steer_pkg::*;
#(
  parameter int SLOTS     = 4,
  parameter int UOP_W     = 4,
  parameter int INSN_W    = 32,
  parameter int SLOT0_MAX = 4,
  parameter int CNT_W     = $clog2(SLOTS + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ucode_busy,
  input  logic [SLOTS-1:0]          win_vld,
  input  logic [SLOTS*UOP_W-1:0]    win_uops,
  input  logic [SLOTS*INSN_W-1:0]   win_insn,
  output logic [CNT_W-1:0]          take_cnt,
  output logic [SLOTS-1:0]          slot_vld,
  output logic [SLOTS*INSN_W-1:0]   slot_insn,
  output logic [UOP_W-1:0]          slot0_uops,
  output logic                      ucode_vld,
  output logic [INSN_W-1:0]         ucode_insn,
  output logic [UOP_W-1:0]          ucode_uops
);
  ent_class_t [SLOTS-1:0] cls;
  logic       [SLOTS-1:0] run;
  logic                   ucode_go;

  genvar k;
  generate
    for (k = 0; k < SLOTS; k++) begin : g_cls
      decode_steer_classify #(.UOP_W(UOP_W), .SLOT0_MAX(SLOT0_MAX)) u_cls (
        .uops (win_uops[k*UOP_W +: UOP_W]),
        .cls  (cls[k])
      );
    end
  endgenerate

  decode_steer_select #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_sel (
    .busy     (ucode_busy),
    .vld      (win_vld),
    .cls      (cls),
    .run      (run),
    .ucode_go (ucode_go),
    .take     (take_cnt)
  );

  // Control flags carry reset; data registers load every cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_vld  <= '0;
      ucode_vld <= 1'b0;
    end else begin
      slot_vld  <= run;
      ucode_vld <= ucode_go;
    end
  end

  always_ff @(posedge clk) begin
    slot_insn  <= win_insn;
    slot0_uops <= win_uops[UOP_W-1:0];
    ucode_insn <= win_insn[INSN_W-1:0];
    ucode_uops <= win_uops[UOP_W-1:0];
  end

  // ---------------- assertions ----------------
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (slot_vld == '0 && !ucode_vld));

  p_slot0_fit_r2: assert property (@(posedge clk) disable iff (rst)
    slot_vld[0] |-> (slot0_uops != '0 && slot0_uops <= UOP_W'(SLOT0_MAX)));

  generate
    for (k = 1; k < SLOTS; k++) begin : g_prefix
      p_slot_prefix_r3: assert property (@(posedge clk) disable iff (rst)
        slot_vld[k] |-> slot_vld[k-1]);
    end
  endgenerate

  p_ucode_long_r4: assert property (@(posedge clk) disable iff (rst)
    ucode_vld |-> (ucode_uops > UOP_W'(SLOT0_MAX)));

  p_take_match_r5: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ($countones(slot_vld) + 32'(ucode_vld) == 32'($past(take_cnt))));

  p_busy_idle_r6: assert property (@(posedge clk) disable iff (rst)
    ucode_busy |=> (slot_vld == '0 && !ucode_vld));

  p_ucode_excl_r8: assert property (@(posedge clk) disable iff (rst)
    ucode_vld |-> (slot_vld == '0));
endmodule

// File: tb/decode_steer_tb_top.sv
`timescale 1ns/1ps
module decode_steer_tb_top;
  localparam int SLOTS = 4, UOP_W = 4, INSN_W = 32, CNT_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic w_busy = 1'b0;
  logic [SLOTS-1:0] w_vld = '0;
  logic [UOP_W-1:0] w_uops [SLOTS];
  logic [INSN_W-1:0] w_insn [SLOTS];
  logic [SLOTS*UOP_W-1:0] win_uops;
  logic [SLOTS*INSN_W-1:0] win_insn;

  logic [CNT_W-1:0] take_cnt;
  logic [SLOTS-1:0] slot_vld;
  logic [SLOTS*INSN_W-1:0] slot_insn;
  logic [UOP_W-1:0] slot0_uops, ucode_uops;
  logic ucode_vld;
  logic [INSN_W-1:0] ucode_insn;

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      win_uops[i*UOP_W +: UOP_W]   = w_uops[i];
      win_insn[i*INSN_W +: INSN_W] = w_insn[i];
    end
  end

  decode_steer dut_i (
    .clk(clk), .rst(rst), .ucode_busy(w_busy), .win_vld(w_vld),
    .win_uops(win_uops), .win_insn(win_insn), .take_cnt(take_cnt),
    .slot_vld(slot_vld), .slot_insn(slot_insn), .slot0_uops(slot0_uops),
    .ucode_vld(ucode_vld), .ucode_insn(ucode_insn), .ucode_uops(ucode_uops)
  );

  typedef struct packed {
    logic                    busy;
    logic [SLOTS-1:0]        mask;
    logic [SLOTS*INSN_W-1:0] ins;
    logic [UOP_W-1:0]        u0;
    logic                    uc;
    logic [INSN_W-1:0]       ucins;
    logic [UOP_W-1:0]        ucu;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: the window must already be set; returns the expected take
  task automatic cyc(input logic b, output int t);
    exp_t e;
    @(negedge clk);
    w_busy = b;
    #1;
    e = '0;
    e.busy = b;
    t = 0;
    if (!b && w_vld[0]) begin
      if (w_uops[0] > 4) begin
        e.uc = 1'b1; e.ucins = w_insn[0]; e.ucu = w_uops[0]; t = 1;
      end else if (w_uops[0] != 0) begin
        e.mask[0] = 1'b1; e.u0 = w_uops[0]; t = 1;
        for (int i = 1; i < SLOTS; i++)
          if (e.mask[i-1] && w_vld[i] && w_uops[i] == 1) begin
            e.mask[i] = 1'b1; t++;
          end
      end
    end
    for (int i = 0; i < SLOTS; i++) e.ins[i*INSN_W +: INSN_W] = w_insn[i];
    chk(take_cnt == CNT_W'(t), b ? "R6 take while busy" : "R5 take_cnt", 64'(take_cnt), 64'(t));
    sb.push_back(e);
    @(posedge clk);
    #1;
  endtask

  // Monitor: compare registered outputs against the record pushed before this edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        if (e.busy) begin
          chk(slot_vld == '0 && !ucode_vld, "R6 idle after busy", {slot_vld, ucode_vld}, 0);
        end else begin
          chk(slot_vld[0] == e.mask[0], "R2 slot0 valid", 64'(slot_vld[0]), 64'(e.mask[0]));
          if (e.mask[0])
            chk(slot_insn[INSN_W-1:0] == e.ins[INSN_W-1:0] && slot0_uops == e.u0,
                "R2 slot0 data", {slot0_uops, slot_insn[INSN_W-1:0]}, {e.u0, e.ins[INSN_W-1:0]});
          chk(slot_vld[SLOTS-1:1] == e.mask[SLOTS-1:1], "R3 slot1..3 valid",
              64'(slot_vld), 64'(e.mask));
          for (int i = 1; i < SLOTS; i++)
            if (e.mask[i])
              chk(slot_insn[i*INSN_W +: INSN_W] == e.ins[i*INSN_W +: INSN_W], "R3 slot data",
                  64'(slot_insn[i*INSN_W +: INSN_W]), 64'(e.ins[i*INSN_W +: INSN_W]));
          chk(ucode_vld == e.uc, "R4 ucode valid", 64'(ucode_vld), 64'(e.uc));
          if (e.uc)
            chk(ucode_insn == e.ucins && ucode_uops == e.ucu, "R4 ucode data",
                {ucode_uops, ucode_insn}, {e.ucu, e.ucins});
          if (e.uc) chk(slot_vld == '0, "R8 exclusive", 64'(slot_vld), 0);
          if (e.mask == '0 && !e.uc)
            chk(slot_vld == '0 && !ucode_vld, "R7 nothing steered", {slot_vld, ucode_vld}, 0);
        end
      end
    end
  end

  int prog_u [64];
  logic [INSN_W-1:0] prog_i [64];
  int prog_n;

  task automatic run_prog(input bit rnd_busy);
    int head, hold, t;
    logic b;
    head = 0; hold = 0;
    while (head < prog_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        w_vld[i]  = (head + i < prog_n);
        w_uops[i] = (head + i < prog_n) ? UOP_W'(prog_u[head+i]) : '0;
        w_insn[i] = (head + i < prog_n) ? prog_i[head+i] : '0;
      end
      if (hold > 0) begin b = 1'b1; hold--; end
      else b = rnd_busy && ($urandom_range(0, 3) == 0);
      cyc(b, t);
      if (!b && w_uops[0] > 4) hold = 2;
      head += t;
    end
  endtask

  task automatic set_win(input logic [3:0] v, input int u0, u1, u2, u3);
    w_vld = v;
    w_uops[0] = UOP_W'(u0); w_uops[1] = UOP_W'(u1);
    w_uops[2] = UOP_W'(u2); w_uops[3] = UOP_W'(u3);
    for (int i = 0; i < SLOTS; i++) w_insn[i] = 32'hC0DE_0000 + i + 16 * checks;
  endtask

  initial begin
    int t;
    for (int i = 0; i < SLOTS; i++) begin w_uops[i] = '0; w_insn[i] = '0; end
    repeat (3) @(posedge clk);
    #1;
    chk(slot_vld == '0 && !ucode_vld, "R1 reset state", {slot_vld, ucode_vld}, 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk(slot_vld == '0 && !ucode_vld, "R1 after reset", {slot_vld, ucode_vld}, 0);

    // R7: invalid head, zero-count head
    set_win(4'b1110, 1, 1, 1, 1); cyc(1'b0, t);
    set_win(4'b1111, 0, 1, 1, 1); cyc(1'b0, t);
    // R3: gap in valids stops group; multi-op at slot 2 stops group
    set_win(4'b1011, 2, 1, 1, 1); cyc(1'b0, t);
    set_win(4'b1111, 4, 1, 3, 1); cyc(1'b0, t);
    // R4: long head; R6: busy with a full window
    set_win(4'b1111, 12, 1, 1, 1); cyc(1'b0, t);
    set_win(4'b1111, 1, 1, 1, 1); cyc(1'b1, t);

    // All single-op stream
    prog_n = 12;
    for (int i = 0; i < prog_n; i++) begin prog_u[i] = 1; prog_i[i] = 32'hA000_0000 + i; end
    run_prog(1'b0);

    // Mixed stream with deferred multi-op and sequencer entries
    prog_n = 16;
    for (int i = 0; i < prog_n; i++) begin
      case (i % 8)
        0: prog_u[i] = 3; 3: prog_u[i] = 2; 5: prog_u[i] = 9; 6: prog_u[i] = 4;
        default: prog_u[i] = 1;
      endcase
      prog_i[i] = 32'hB000_0000 + i;
    end
    run_prog(1'b0);

    // Randomised stream with random sequencer-busy cycles
    for (int r = 0; r < 20; r++) begin
      prog_n = 48;
      for (int i = 0; i < prog_n; i++) begin
        int s;
        s = $urandom_range(0, 9);
        prog_u[i] = (s < 6) ? 1 : (s < 9) ? $urandom_range(2, 4) : $urandom_range(5, 15);
        prog_i[i] = $urandom;
      end
      run_prog(1'b1);
    end

    w_vld = '0;
    cyc(1'b0, t);
    cyc(1'b0, t);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule